// File: doc/BRIEF.md
# Auto-Reload Down-Counting Timer Channel

This block is one channel of a periodic timer. A 32-bit counter counts down at the system clock divided by a selectable power-of-four prescale. When the counter is already zero at a count step, it reloads from a programmable reload value instead of wrapping. It also raises a sticky underflow flag. The flag drives an interrupt line whenever the interrupt enable bit in the control word is set. Software clears the flag by writing the control word with the flag bit at zero.

A parent unit gates the channel through the `run_i` input. Software reaches four word registers over a simple single-cycle read/write port. Index 0 holds the reload value, index 1 the live counter, index 2 the control word, and index 3 a capture register. The capture register exists only when the channel is built with capture support. An access to an index the channel does not implement reads as zero and changes nothing. It also produces a one-cycle error pulse.

Top module: `reload_down_timer`

## Requirements
- R1: After reset the reload value and the counter both read 0xFFFFFFFF, the control word reads 0 and `irq_o` is low.
- R2: The word index is `bus_addr[ADDR_W-1:2]`: 0 is the reload value, 1 the counter, 2 the control word, 3 the capture register. `bus_addr[1:0]` has no effect.
- R3: Control bits 2:0 select the count rate. For codes 0, 1, 2, 3 and 4 the counter steps once every 4, 16, 64, 256 and 1024 clocks while `run_i` is high. After `run_i` rises, the first step falls on the Nth rising edge at which `run_i` is sampled high, where N is the divisor.
- R4: With clock-select code 5, 6 or 7 the counter never steps.
- R5: A count step taken while the counter is 0 loads the reload value into the counter and sets the underflow flag. The flag reads back in control bit 8.
- R6: While `run_i` is low the counter and the flag hold their values, and the prescale phase returns to zero.
- R7: A write to index 1 sets the counter to the written value on that clock edge. If a count step falls in the same cycle, the write wins.
- R8: A write to index 2 stores bits 7:0. The interrupt enable is bit 5. A write with bit 8 at 0 clears the flag; a write with bit 8 at 1 leaves it as it is. A read of index 2 returns the stored bits 7:0, the flag in bit 8, and zero in every higher bit.
- R9: `irq_o` is high exactly when the underflow flag and control bit 5 are both set.
- R10: A write to the control word cancels any count step in that cycle and restarts the prescale phase at zero.
- R11: When built with `HAS_CAPTURE`=1, index 3 is a read/write register that resets to 0. When built with `HAS_CAPTURE`=0, index 3 counts as an unimplemented index.
- R12: An access to an unimplemented index reads as 0 and does not change any register. `bad_acc_o` goes high for one cycle after that access; after any other cycle it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | Count enable from the parent unit |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address; bits above 1 give the word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the index |
| irq_o | output | 1 | Underflow interrupt |
| bad_acc_o | output | 1 | One-cycle pulse after an access to an unimplemented index |

## Verification
The counting function is driven with several patterns:
- Run windows of exactly N and N-1 enabled clocks separate the divisor codes 0, 1 and 4 from their neighbours.
- A window that starts at zero separates a clean reload-and-flag from a wrap to all ones.
- A long run with a reserved code shows that stepping stops.
- A control write placed three clocks into a run window separates a prescale restart from a phase that carries on.
- Flag handling is tried with the flag bit written both as one and as zero, and with the interrupt enable both off and on, so the gating and the sticky clear can be told apart.
- A second instance built without capture shows the difference in decoding index 3.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // widest prescale divisor is 1024, so the phase counter needs 10 bits
    localparam int PSC_W = 10;

    typedef enum logic [1:0] {
        IDX_RELOAD  = 2'd0,
        IDX_COUNT   = 2'd1,
        IDX_CONTROL = 2'd2,
        IDX_CAPTURE = 2'd3
    } reg_idx_e;

    // stored control bits 7:0, laid out in bit order
    typedef struct packed {
        logic [1:0] cap_mode;   // 7:6 kept, no function
        logic       irq_en;     // 5
        logic [1:0] edge_mode;  // 4:3 kept, no function
        logic [2:0] rate_sel;   // 2:0
    } ctrl_t;

    localparam int FLAG_BIT = 8;

    function automatic logic rate_ok(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic [PSC_W-1:0] rate_last(input logic [2:0] code);
        case (code)
            3'd0:    return PSC_W'(3);
            3'd1:    return PSC_W'(15);
            3'd2:    return PSC_W'(63);
            3'd3:    return PSC_W'(255);
            default: return PSC_W'(1023);
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic [2:0] rate_sel,
    output logic       tick_o
);

    logic [PSC_W-1:0] phase_q;
    logic [PSC_W-1:0] last;
    logic             at_end;

    assign last   = rate_last(rate_sel);
    assign at_end = phase_q >= last;
    assign tick_o = run && !restart && rate_ok(rate_sel) && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run || restart || at_end) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PSC_W'(1);
        end
    end

    // R6
    stopped_phase_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> phase_q == '0);

    // R10
    restart_phase_clear_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> phase_q == '0);

    // R3
    tick_wraps_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> phase_q == '0);

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cnt_we,
    input  logic [DATA_W-1:0] cnt_wd,
    input  logic [DATA_W-1:0] reload,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] cnt_o,
    output logic              flag_o
);

    logic [DATA_W-1:0] cnt_q;
    logic              flag_q;
    logic              wrap;

    assign wrap = tick && !cnt_we && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '1;
        end else if (cnt_we) begin
            cnt_q <= cnt_wd;
        end else if (tick) begin
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - DATA_W'(1);
        end
    end

    // a wrap and a clear never share a cycle; if they did, the wrap wins
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (wrap) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign cnt_o  = cnt_q;
    assign flag_o = flag_q;

    // R5
    wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_we && cnt_q == '0) |=> (flag_q && cnt_q == $past(reload)));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_we) |=> $stable(cnt_q));

    // R7
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> cnt_q == $past(cnt_wd));

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !wrap) |=> !flag_q);

endmodule

// File: rtl/reload_down_timer.sv
module reload_down_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 5,
    parameter bit HAS_CAPTURE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              bad_acc_o
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  idx;
    logic [1:0]        addr_unused;
    logic              idx_ok;
    logic              hi_zero;
    reg_idx_e          sel;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] capture_q;
    ctrl_t             ctrl_q;
    logic              bad_q;
    logic              we_reload, we_count, we_ctrl, we_capture;
    logic              tick;
    logic [DATA_W-1:0] cnt;
    logic              flag;

    assign idx         = bus_addr[ADDR_W-1:2];
    assign addr_unused = bus_addr[1:0];
    assign hi_zero     = (idx >> 2) == '0;
    assign sel         = reg_idx_e'(idx[1:0]);
    assign idx_ok      = hi_zero && (sel != IDX_CAPTURE || HAS_CAPTURE);

    assign we_reload  = bus_wr && idx_ok && sel == IDX_RELOAD;
    assign we_count   = bus_wr && idx_ok && sel == IDX_COUNT;
    assign we_ctrl    = bus_wr && idx_ok && sel == IDX_CONTROL;
    assign we_capture = bus_wr && idx_ok && sel == IDX_CAPTURE;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '1;
            ctrl_q   <= '0;
            bad_q    <= 1'b0;
        end else begin
            if (we_reload) reload_q <= bus_wdata;
            if (we_ctrl)   ctrl_q   <= ctrl_t'(bus_wdata[7:0]);
            bad_q <= (bus_wr || bus_rd) && !idx_ok;
        end
    end

    generate
        if (HAS_CAPTURE) begin : g_cap
            logic [DATA_W-1:0] cap_q;
            always_ff @(posedge clk) begin
                if (rst)             cap_q <= '0;
                else if (we_capture) cap_q <= bus_wdata;
            end
            assign capture_q = cap_q;
        end else begin : g_nocap
            assign capture_q = '0;
        end
    endgenerate

    tmr_prescaler u_psc (
        .clk      (clk),
        .rst      (rst),
        .run      (run_i),
        .restart  (we_ctrl),
        .rate_sel (ctrl_q.rate_sel),
        .tick_o   (tick)
    );

    tmr_count_core #(.DATA_W(DATA_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cnt_we   (we_count),
        .cnt_wd   (bus_wdata),
        .reload   (reload_q),
        .flag_clr (we_ctrl && !bus_wdata[FLAG_BIT]),
        .cnt_o    (cnt),
        .flag_o   (flag)
    );

    always_comb begin
        bus_rdata = '0;
        if (idx_ok) begin
            case (sel)
                IDX_RELOAD:  bus_rdata = reload_q;
                IDX_COUNT:   bus_rdata = cnt;
                IDX_CONTROL: bus_rdata = {{(DATA_W-9){1'b0}}, flag, ctrl_q};
                default:     bus_rdata = capture_q;
            endcase
        end
    end

    assign irq_o     = flag && ctrl_q.irq_en;
    assign bad_acc_o = bad_q;

    // R12
    bad_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && !idx_ok) |=> bad_acc_o);

    // R12
    bad_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr || bus_rd) |=> !bad_acc_o);

    // R12
    reload_guard_chk: assert property (@(posedge clk) disable iff (rst)
        !we_reload |=> $stable(reload_q));

    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> (flag && ctrl_q.irq_en));

endmodule

// File: tb/tb_reload_down_timer.sv
module tb_reload_down_timer;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run_i = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] rdata, rdata_nc;
    logic          irq, irq_nc, bad, bad_nc;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [DW-1:0] exp;
        bit            nc;
        string         tag;
    } rd_item_t;
    rd_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    reload_down_timer #(.DATA_W(DW), .ADDR_W(AW), .HAS_CAPTURE(1'b1)) dut (
        .clk(clk), .rst(rst), .run_i(run_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
        .irq_o(irq), .bad_acc_o(bad));

    reload_down_timer #(.DATA_W(DW), .ADDR_W(AW), .HAS_CAPTURE(1'b0)) dut_nc (
        .clk(clk), .rst(rst), .run_i(run_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_nc),
        .irq_o(irq_nc), .bad_acc_o(bad_nc));

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares reads against the scoreboard queue
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (bus_rd) begin
            if (sb_q.size() == 0) begin
                check(1, 0, "scoreboard underrun");
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                check(it.nc ? rdata_nc : rdata, it.exp, it.tag);
            end
        end
    end

    task automatic wr(input int idx, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = AW'(idx << 2); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int idx, input logic [DW-1:0] exp, input bit nc, input string tag,
                      input int low = 0);
        rd_item_t it;
        it.exp = exp; it.nc = nc; it.tag = tag;
        @(negedge clk);
        sb_q.push_back(it);
        bus_addr = AW'((idx << 2) | low); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic run_edges(input int n);
        @(negedge clk);
        run_i = 1'b1;
        repeat (n) @(negedge clk);
        run_i = 1'b0;
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(0, 1, "watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(0, 32'hFFFF_FFFF, 0, "R1 reload reset");
        rd(1, 32'hFFFF_FFFF, 0, "R1 counter reset");
        rd(2, 32'h0, 0, "R1 control reset");
        #1 check(irq, 0, "R1 irq low");
        // R11 capture resets to zero
        rd(3, 32'h0, 0, "R11 capture reset");
        // R2 low address bits ignored
        rd(0, 32'hFFFF_FFFF, 0, "R2 low bits ignored", 3);

        // R5 underflow reload and flag, R9 irq
        wr(0, 32'd5);
        wr(1, 32'd2);
        wr(2, 32'h20);
        run_edges(8);
        rd(1, 32'd0, 0, "R3 two steps at div4");
        rd(2, 32'h20, 0, "R5 no flag before wrap");
        run_edges(4);
        rd(1, 32'd5, 0, "R5 reload on wrap");
        rd(2, 32'h120, 0, "R5 flag set");
        #1 check(irq, 1, "R9 irq with enable");
        run_edges(4);
        rd(2, 32'h120, 0, "R5 flag sticky");
        rd(1, 32'd4, 0, "R3 step after reload");

        // R8 flag write one keeps, write zero clears
        wr(2, 32'h120);
        rd(2, 32'h120, 0, "R8 bit8 one keeps flag");
        wr(2, 32'h20);
        rd(2, 32'h20, 0, "R8 bit8 zero clears flag");
        #1 check(irq, 0, "R9 irq drops with flag");

        // R9 gating by enable
        wr(1, 32'd0);
        wr(2, 32'h00);
        run_edges(4);
        rd(2, 32'h100, 0, "R5 flag with irq off");
        #1 check(irq, 0, "R9 irq gated off");
        wr(2, 32'h120);
        #1 check(irq, 1, "R9 irq after enable");
        wr(2, 32'h00);

        // R8 stored bits and zero high bits
        wr(2, 32'hFFFF_FEFF);
        rd(2, 32'h0000_00FF, 0, "R8 stored field mask");

        // R4 reserved codes do not count
        wr(1, 32'd77);
        run_edges(200);
        rd(1, 32'd77, 0, "R4 code7 no step");
        wr(2, 32'h05);
        run_edges(200);
        rd(1, 32'd77, 0, "R4 code5 no step");

        // R3 code 1 divides by 16
        wr(2, 32'h01);
        wr(1, 32'd10);
        run_edges(15);
        rd(1, 32'd10, 0, "R3 div16 not yet");
        run_edges(32);
        rd(1, 32'd8, 0, "R3 div16 two steps");

        // R3 code 4 divides by 1024
        wr(2, 32'h04);
        wr(1, 32'd3);
        run_edges(1023);
        rd(1, 32'd3, 0, "R3 div1024 not yet");
        run_edges(2048);
        rd(1, 32'd1, 0, "R3 div1024 two steps");

        // R6 stopped: counter zero never wraps
        wr(2, 32'h00);
        wr(1, 32'd0);
        repeat (40) @(negedge clk);
        rd(1, 32'd0, 0, "R6 held while stopped");
        rd(2, 32'h0, 0, "R6 no flag while stopped");

        // R7 counter write immediate
        wr(1, 32'h1234_5678);
        rd(1, 32'h1234_5678, 0, "R7 counter write");

        // R10 control write restarts prescale phase
        wr(1, 32'd50);
        @(negedge clk);
        run_i = 1'b1;
        repeat (3) @(negedge clk);
        bus_addr = AW'(2 << 2); bus_wdata = 32'h0; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        run_i = 1'b0;
        rd(1, 32'd50, 0, "R10 restart delays step");
        run_edges(4);
        rd(1, 32'd49, 0, "R10 step after full period");

        // R11 capture register on both builds
        wr(3, 32'hA5A5_0001);
        #1 check(bad, 0, "R11 capture write valid");
        check(bad_nc, 1, "R11 index3 invalid without capture");
        rd(3, 32'hA5A5_0001, 0, "R11 capture readback");
        rd(3, 32'h0, 1, "R11 no-capture reads zero");

        // R12 invalid index
        wr(0, 32'h0000_0100);
        wr(5, 32'hDEAD_0000);
        #1 check(bad, 1, "R12 error pulse after write");
        @(negedge clk);
        #1 check(bad, 0, "R12 error pulse one cycle");
        rd(5, 32'h0, 0, "R12 invalid read zero");
        #1 check(bad, 1, "R12 error pulse after read");
        rd(0, 32'h0000_0100, 0, "R12 reload untouched");
        rd(1, 32'd49, 0, "R12 counter untouched");
        rd(2, 32'h0, 0, "R12 control untouched");

        repeat (2) @(negedge clk);
        check(sb_q.size(), 0, "scoreboard drained");
        report();
    end

endmodule